// File: doc/BRIEF.md
# Wide-to-Narrow Byte Lane Steering

This block sits between a 32-bit processor data bus and a peripheral that is only one byte wide. On every bus clock edge where the address strobe is low, it decodes the active-low byte enables, qualified by an active-low narrow-size indication. It then captures a set of active-low swap enables. Each swap enable drives a transceiver that routes one upper byte lane (1, 2 or 3) onto lane 0. The block captures the two low address bits for the narrow device in the same way.

Both outputs stay registered from one strobe to the next. Only one lane can be routed at a time: an upper lane is chosen only when every lane below it is off. When the processor enables all four lanes at once, only lane 0 counts and no swap is made. Byte-enable patterns with no lane asserted, or with a gap between asserted lanes, are never issued by the processor and give no defined result. The block produces no byte-high-enable output.

Top module: `byte_lane_steer`

## Requirements
- R1: While `rst` is high at a clock edge, every bit of `swap_en_n` becomes 1 (inactive) and `narrow_addr` becomes 0 after that edge, whatever the other inputs are.
- R2: `swap_en_n[0]` (the lane 1 route) goes low one clock after an edge with `ads_n`=0, `bs8_n`=0, `be_n[1]`=0 and `be_n[0]`=1. A strobe whose lowest enabled lane is lane 0 leaves all swap enables high.
- R3: `swap_en_n[1]` (the lane 2 route) goes low one clock after an edge with `ads_n`=0, `bs8_n`=0, `be_n[2]`=0 and `be_n[1:0]`=2'b11.
- R4: `swap_en_n[2]` (the lane 3 route) goes low one clock after an edge with `ads_n`=0, `bs8_n`=0, `be_n[3]`=0 and `be_n[2:0]`=3'b111.
- R5: At an edge with `ads_n`=1, neither `swap_en_n` nor `narrow_addr` changes, whatever `be_n` and `bs8_n` carry.
- R6: A strobe with `be_n`=4'b0000 and `bs8_n`=0 leaves all swap enables high after the edge.
- R7: A strobe with `bs8_n`=1 leaves all swap enables high after the edge.
- R8: After a strobe, `narrow_addr` holds the index of the lowest lane whose `be_n` bit is 0, in binary (lane 0 gives 2'b00, lane 3 gives 2'b11).
- R9: At no time is more than one bit of `swap_en_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; the block samples on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ads_n | input | 1 | Address strobe, active low; a low level marks a new bus cycle to capture |
| bs8_n | input | 1 | Narrow (8-bit) bus size indication, active low |
| be_n | input | 4 | Byte enables, active low, bit i for byte lane i |
| swap_en_n | output | 3 | Registered swap enables, active low; bit j routes lane j+1 onto lane 0 |
| narrow_addr | output | 2 | Registered low address bits for the narrow device |

## Verification
Two things can fall on one edge: a new capture and the release of the previous route. When strobes come back to back, one lane's enable must rise in the same cycle another lane's enable falls, and the two must never overlap. The bench provokes this by sweeping every ordered pair of legal byte-enable patterns, in both size modes, both with and without an idle cycle between the two strobes. After each edge it compares the full output word, both enables and the address, against a model computed in the bench. A reset applied during a live strobe with a swap pattern also tests whether reset wins over capture on the same edge.

// File: rtl/lane_steer_pkg.sv
package lane_steer_pkg;

  // Default number of byte lanes on the wide side of the bus.
  localparam int unsigned WIDE_LANES = 4;

  // Width of a lane index for a given lane count (at least one bit).
  function automatic int unsigned lane_idx_width(input int unsigned lanes);
    return (lanes > 2) ? $clog2(lanes) : 1;
  endfunction

endpackage

// File: rtl/lane_enable_decode.sv
module lane_enable_decode #(
  parameter int unsigned LANES = lane_steer_pkg::WIDE_LANES,
  localparam int unsigned IDXW = lane_steer_pkg::lane_idx_width(LANES)
) (
  input  logic [LANES-1:0] lane_on,    // active-high byte enables
  input  logic             narrow,     // active-high narrow-size flag
  output logic [LANES-2:0] route_req,  // active-high swap request, bit j = lane j+1
  output logic [IDXW-1:0]  low_lane    // index of lowest enabled lane
);

  // below_off[i] is high when every lane under lane i is disabled.
  logic [LANES-1:0] below_off;

  assign below_off[0] = 1'b1;

  genvar gi;
  generate
    for (gi = 1; gi < LANES; gi++) begin : g_chain
      assign below_off[gi]   = below_off[gi-1] & ~lane_on[gi-1];
      assign route_req[gi-1] = narrow & lane_on[gi] & below_off[gi];
    end
  endgenerate

  // Priority encode from the top so the lowest enabled lane wins.
  always_comb begin
    low_lane = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (lane_on[i]) low_lane = IDXW'(i);
    end
  end

endmodule

// File: rtl/strobe_capture_reg.sv
module strobe_capture_reg #(
  parameter int unsigned    W        = 1,
  parameter logic [W-1:0]   RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         capture,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RESET_VAL;
    end else if (capture) begin
      q <= d;
    end
  end

endmodule

// File: rtl/byte_lane_steer.sv
module byte_lane_steer #(
  parameter int unsigned LANES = lane_steer_pkg::WIDE_LANES,
  localparam int unsigned IDXW = lane_steer_pkg::lane_idx_width(LANES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ads_n,
  input  logic             bs8_n,
  input  logic [LANES-1:0] be_n,
  output logic [LANES-2:0] swap_en_n,
  output logic [IDXW-1:0]  narrow_addr
);

  logic [LANES-1:0] lane_on;
  logic             narrow;
  logic             strobe;
  logic [LANES-2:0] route_req;
  logic [IDXW-1:0]  low_lane;

  assign lane_on = ~be_n;
  assign narrow  = ~bs8_n;
  assign strobe  = ~ads_n;

  lane_enable_decode #(
    .LANES (LANES)
  ) u_decode (
    .lane_on   (lane_on),
    .narrow    (narrow),
    .route_req (route_req),
    .low_lane  (low_lane)
  );

  // Swap enables: stored active low, all inactive out of reset.
  strobe_capture_reg #(
    .W         (LANES - 1),
    .RESET_VAL ({(LANES-1){1'b1}})
  ) u_swap_hold (
    .clk     (clk),
    .rst     (rst),
    .capture (strobe),
    .d       (~route_req),
    .q       (swap_en_n)
  );

  // Narrow-device address bits.
  strobe_capture_reg #(
    .W         (IDXW),
    .RESET_VAL ('0)
  ) u_addr_hold (
    .clk     (clk),
    .rst     (rst),
    .capture (strobe),
    .d       (low_lane),
    .q       (narrow_addr)
  );

endmodule

// File: rtl/byte_lane_steer_chk.sv
module byte_lane_steer_chk #(
  parameter int unsigned LANES = lane_steer_pkg::WIDE_LANES,
  localparam int unsigned IDXW = lane_steer_pkg::lane_idx_width(LANES)
) (
  input logic             clk,
  input logic             rst,
  input logic             ads_n,
  input logic             bs8_n,
  input logic [LANES-1:0] be_n,
  input logic [LANES-2:0] swap_en_n,
  input logic [IDXW-1:0]  narrow_addr
);

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R1
  always @(negedge clk) begin
    if (rst_q) begin
      reset_state_chk: assert ((&swap_en_n) && (narrow_addr == '0));
    end
  end

  // R9
  one_route_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~swap_en_n));

  // R5
  hold_between_strobes_chk: assert property (@(posedge clk) disable iff (rst)
    ads_n |=> ($stable(swap_en_n) && $stable(narrow_addr)));

  // R7
  wide_size_no_route_chk: assert property (@(posedge clk) disable iff (rst)
    (!ads_n && bs8_n) |=> (&swap_en_n));

  // R6
  all_lanes_no_route_chk: assert property (@(posedge clk) disable iff (rst)
    (!ads_n && (be_n == '0)) |=> (&swap_en_n));

  // R8
  lane0_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (!ads_n && !be_n[0]) |=> (narrow_addr == '0));

  genvar gj;
  generate
    for (gj = 1; gj < LANES; gj++) begin : g_lane
      // R2 R3 R4: one lane per generated property
      upper_route_chk: assert property (@(posedge clk) disable iff (rst)
        (!ads_n && !bs8_n && !be_n[gj] && (&be_n[gj-1:0])) |=> !swap_en_n[gj-1]);
    end
  endgenerate

endmodule

bind byte_lane_steer byte_lane_steer_chk #(.LANES(LANES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ads_n       (ads_n),
  .bs8_n       (bs8_n),
  .be_n        (be_n),
  .swap_en_n   (swap_en_n),
  .narrow_addr (narrow_addr)
);

// File: tb/test_byte_lane_steer.sv
module test_byte_lane_steer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ads_n = 1'b1;
  logic       bs8_n = 1'b1;
  logic [3:0] be_n = 4'hF;
  logic [2:0] swap_en_n;
  logic [1:0] narrow_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [2:0] exp_sw_n = 3'b111;
  logic [1:0] exp_addr = 2'b00;
  logic [3:0] legal [10];

  always #2 clk = ~clk;

  byte_lane_steer i_byte_lane_steer (
    .clk         (clk),
    .rst         (rst),
    .ads_n       (ads_n),
    .bs8_n       (bs8_n),
    .be_n        (be_n),
    .swap_en_n   (swap_en_n),
    .narrow_addr (narrow_addr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One bus clock: drive after a falling edge, check at the next falling edge.
  task automatic step(input logic [3:0] b, input logic bs, input logic ad,
                      input logic r, input string tag);
    int k;
    logic [3:0] on;
    @(negedge clk);
    be_n = b; bs8_n = bs; ads_n = ad; rst = r;
    on = ~b;
    if (r) begin
      exp_sw_n = 3'b111; exp_addr = 2'b00;
    end else if (!ad) begin
      k = 0;
      for (int i = 3; i >= 0; i--) if (on[i]) k = i;
      exp_addr = 2'(k);
      exp_sw_n = (!bs && k >= 1) ? ~(3'b001 << (k - 1)) : 3'b111;
    end
    @(negedge clk);
    chk(swap_en_n === exp_sw_n, tag, int'(swap_en_n), int'(exp_sw_n));
    chk(narrow_addr === exp_addr, (ad && !r) ? tag : (r ? "R1" : "R8"),
        int'(narrow_addr), int'(exp_addr));
    chk($countones(~swap_en_n) <= 1, "R9", int'(swap_en_n), 7);
  endtask

  function automatic string cap_tag(input logic [3:0] b, input logic bs);
    logic [3:0] on;
    on = ~b;
    if (bs) return "R7";
    if (on == 4'hF) return "R6";
    if (on[0]) return "R2";
    if (on[1]) return "R2";
    if (on[2]) return "R3";
    return "R4";
  endfunction

  initial begin
    int n = 0;
    for (int lo = 0; lo < 4; lo++)
      for (int hi = lo; hi < 4; hi++) begin
        logic [3:0] m = '0;
        for (int i = lo; i <= hi; i++) m[i] = 1'b1;
        legal[n] = ~m;
        n++;
      end

    // R1: reset state
    repeat (2) step(4'b1101, 1'b0, 1'b0, 1'b1, "R1");

    // Exhaustive pairs, both sizes, with and without an idle cycle between.
    for (int p = 0; p < 10; p++)
      for (int q = 0; q < 10; q++)
        for (int s = 0; s < 2; s++) begin
          step(legal[p], 1'(s), 1'b0, 1'b0, cap_tag(legal[p], 1'(s)));
          step(legal[q], 1'b0, 1'b0, 1'b0, cap_tag(legal[q], 1'b0));
          step(~legal[q], ~1'(s), 1'b1, 1'b0, "R5");
          step(4'b0101, 1'(s), 1'b1, 1'b0, "R5");
          step(legal[q], 1'(s), 1'b0, 1'b0, cap_tag(legal[q], 1'(s)));
        end

    // R1: reset wins over a live strobe carrying a lane 3 route.
    step(4'b0111, 1'b0, 1'b0, 1'b0, "R4");
    step(4'b0111, 1'b0, 1'b0, 1'b1, "R1");
    step(4'b1011, 1'b0, 1'b1, 1'b0, "R5");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule